// File: doc/BRIEF.md
# Microprogrammed Shift-Add Multiplier Sequencer

This block multiplies two unsigned operands with a shift-and-add datapath whose control comes from a tiny read-only microprogram instead of a hand-coded state machine. A control address register points at one of five 12-bit control words. Each word carries two candidate successor addresses, a two-bit branch selector and four unencoded datapath strobes. Every clock, the next-address logic picks one of the two successors. Its choice depends on the selector, the start input, the low multiplier bit and the counter-zero flag.

The datapath holds the multiplicand register, a partial-product register with a carry bit, the multiplier/low-product register and a down counter. Status flags reach only the next-address logic. The strobes therefore depend on the current control word alone, and no register sits between the control store and the datapath. A user holds the operands steady, raises `start_i` while `idle_o` is high, and reads `product_o` when `idle_o` returns high.

Top module: `mpy_seq_top`

## Requirements
- R1: While `rst_ni` is low and on its release, `idle_o` is 1 and `product_o` is 0.
- R2: While idle with `start_i` low, the block stays idle on every following cycle.
- R3: After a run completes, `product_o` equals the unsigned product of the multiplicand and multiplier that were present on the cycle after start was accepted.
- R4: One run keeps `idle_o` low for exactly 1 + 2·WIDTH + (number of 1 bits in the multiplier) cycles: one set-up word, then per bit a test word and a shift word, plus an add word for each 1 bit.
- R5: `start_i` has no effect while a run is in progress. The product and the run length are unchanged by it.
- R6: While idle with `start_i` low, `product_o` holds its value even when the operand inputs change.
- R7: When `start_i` is high in an idle cycle, the next cycle is busy. A start held high across a completion gives exactly one idle cycle between runs.
- R8: The control address never leaves the five programmed words (0 to 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiply; sampled only in the idle word |
| mcand_i | input | WIDTH | Multiplicand, captured in the set-up word |
| mplier_i | input | WIDTH | Multiplier, captured in the set-up word |
| product_o | output | 2·WIDTH | {partial product, low product} |
| idle_o | output | 1 | High while the control address is 0 |

## Verification
A wrong control word or a wrong branch decision shows up as a wrong busy length: an add skipped or repeated changes the cycle count by one as well as the product. The damage is visible at the very next return to idle. A mis-shifted carry or a counter off by one corrupts the high product bits and lengthens or shortens the run by two cycles, so every completion is scored on both product and duration. Start and operand changes during busy or idle periods check that nothing outside the idle word reacts to them.

// File: rtl/mpy_seq_pkg.sv
package mpy_seq_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NUM_WORDS = 5;

  typedef enum logic [1:0] {
    BR_ALWAYS = 2'b00,
    BR_START  = 2'b01,
    BR_LSB    = 2'b10,
    BR_ZERO   = 2'b11
  } br_sel_e;

  typedef struct packed {
    logic init;
    logic add;
    logic clr_c;
    logic shift_dec;
  } strobes_t;

  typedef struct packed {
    br_sel_e           sel;
    logic [ADDR_W-1:0] addr_a;
    logic [ADDR_W-1:0] addr_b;
    strobes_t          strobes;
  } uword_t;

  localparam logic [ADDR_W-1:0] W_IDLE  = 3'd0;
  localparam logic [ADDR_W-1:0] W_SETUP = 3'd1;
  localparam logic [ADDR_W-1:0] W_TEST  = 3'd2;
  localparam logic [ADDR_W-1:0] W_ADD   = 3'd3;
  localparam logic [ADDR_W-1:0] W_SHIFT = 3'd4;

  function automatic uword_t ucode(input logic [ADDR_W-1:0] addr);
    uword_t w;
    w = '0;
    case (addr)
      W_IDLE:  begin w.sel = BR_START;  w.addr_a = W_IDLE;  w.addr_b = W_SETUP; end
      W_SETUP: begin w.sel = BR_ALWAYS; w.addr_a = W_TEST;  w.addr_b = W_TEST;  w.strobes.init = 1'b1; end
      W_TEST:  begin w.sel = BR_LSB;    w.addr_a = W_SHIFT; w.addr_b = W_ADD; end
      W_ADD:   begin w.sel = BR_ALWAYS; w.addr_a = W_SHIFT; w.addr_b = W_SHIFT; w.strobes.add = 1'b1; end
      W_SHIFT: begin
        w.sel = BR_ZERO; w.addr_a = W_TEST; w.addr_b = W_IDLE;
        w.strobes.clr_c = 1'b1; w.strobes.shift_dec = 1'b1;
      end
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/mpy_ctrl_store.sv
module mpy_ctrl_store
  import mpy_seq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output uword_t            word_o
);
  always_comb word_o = ucode(addr_i);
endmodule

// File: rtl/mpy_next_addr.sv
module mpy_next_addr
  import mpy_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  br_sel_e           sel_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic              start_i,
  input  logic              lsb_i,
  input  logic              zero_i,
  output logic [ADDR_W-1:0] car_o
);
  logic take_b;
  logic [ADDR_W-1:0] car_q;

  always_comb begin
    unique case (sel_i)
      BR_ALWAYS: take_b = 1'b0;
      BR_START:  take_b = start_i;
      BR_LSB:    take_b = lsb_i;
      BR_ZERO:   take_b = zero_i;
      default:   take_b = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) car_q <= W_IDLE;
    else         car_q <= take_b ? addr_b_i : addr_a_i;
  end

  assign car_o = car_q;
endmodule

// File: rtl/mpy_datapath.sv
module mpy_datapath
  import mpy_seq_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  strobes_t         strobes_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic             lsb_o,
  output logic             zero_o,
  output logic [2*WIDTH-1:0] product_o
);
  logic [WIDTH-1:0] b_q, a_q, q_q;
  logic             c_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH:0]   sum;

  assign sum = {1'b0, a_q} + {1'b0, b_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q <= '0; a_q <= '0; q_q <= '0; c_q <= 1'b0; cnt_q <= '0;
    end else if (strobes_i.init) begin
      b_q   <= mcand_i;
      q_q   <= mplier_i;
      a_q   <= '0;
      c_q   <= 1'b0;
      cnt_q <= CNT_W'(WIDTH - 1);
    end else if (strobes_i.add) begin
      {c_q, a_q} <= sum;
    end else if (strobes_i.shift_dec) begin
      // carry enters the top of A, A[0] enters the top of Q
      a_q   <= {c_q, a_q[WIDTH-1:1]};
      q_q   <= {a_q[0], q_q[WIDTH-1:1]};
      cnt_q <= cnt_q - 1'b1;
      if (strobes_i.clr_c) c_q <= 1'b0;
    end else if (strobes_i.clr_c) begin
      c_q <= 1'b0;
    end
  end

  assign lsb_o     = q_q[0];
  assign zero_o    = (cnt_q == '0);
  assign product_o = {a_q, q_q};
endmodule

// File: rtl/mpy_seq_top.sv
module mpy_seq_top
  import mpy_seq_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] product_o,
  output logic               idle_o
);
  logic [ADDR_W-1:0] car;
  uword_t            uword;
  logic              lsb, zero;

  mpy_ctrl_store u_store (
    .addr_i (car),
    .word_o (uword)
  );

  mpy_next_addr u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (uword.sel),
    .addr_a_i (uword.addr_a),
    .addr_b_i (uword.addr_b),
    .start_i  (start_i),
    .lsb_i    (lsb),
    .zero_i   (zero),
    .car_o    (car)
  );

  mpy_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobes_i (uword.strobes),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .lsb_o     (lsb),
    .zero_o    (zero),
    .product_o (product_o)
  );

  assign idle_o = (car == W_IDLE);
endmodule

// File: rtl/mpy_seq_checker.sv
module mpy_seq_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               idle_o,
  input logic [2*WIDTH-1:0] product_o,
  input logic [2:0]         car,
  input logic               zero
);
  localparam int unsigned MAX_RUN = 3 * WIDTH + 1;
  localparam int unsigned RUN_W   = $clog2(MAX_RUN + 2) + 1;

  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (idle_o) run_cnt <= '0;
    else             run_cnt <= run_cnt + 1'b1;
  end

  a_r1_reset_idle: assert property (@(posedge clk_i) !rst_ni |-> idle_o);

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o && !start_i |=> idle_o);

  a_r6_product_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o && !start_i |=> $stable(product_o));

  a_r7_start_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o && start_i |=> !idle_o);

  // busy only ends from the shift word with the counter at zero
  a_r5_busy_persists: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o && !(car == 3'd4 && zero) |=> !idle_o);

  a_r8_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    car <= 3'd4);

  a_r4_run_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt <= RUN_W'(MAX_RUN));
endmodule

bind mpy_seq_top mpy_seq_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .idle_o    (idle_o),
  .product_o (product_o),
  .car       (car),
  .zero      (zero)
);

// File: tb/mpy_seq_top_bench.sv
module mpy_seq_top_bench;
  localparam int unsigned W = 8;

  typedef struct {
    logic [2*W-1:0] prod;
    int             cycles;
    bit             poked;
  } exp_t;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [W-1:0]     mcand_i = '0;
  logic [W-1:0]     mplier_i = '0;
  logic [2*W-1:0]   product_o;
  logic             idle_o;

  int tests = 0, fails = 0, busy = 0, done_cnt = 0, cyc = 0;
  bit finished = 1'b0;
  exp_t exp_q[$];

  always #2 clk_i = ~clk_i;

  mpy_seq_top #(.WIDTH(W)) u_mpy_seq_top (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  // monitor: score each completion against the queue
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!idle_o) busy++;
      else if (busy > 0) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected run", busy, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(product_o == e.prod, e.poked ? "R5 product" : "R3 product", product_o, e.prod);
          chk(busy == e.cycles, e.poked ? "R5 cycles" : "R4 cycles", busy, e.cycles);
        end
        busy = 0;
        done_cnt++;
      end
    end
  end

  task automatic push_exp(input logic [W-1:0] a, input logic [W-1:0] b, input bit poked);
    exp_t e;
    e.prod   = (2*W)'(a) * (2*W)'(b);
    e.cycles = 1 + 2*W + $countones(b);
    e.poked  = poked;
    exp_q.push_back(e);
  endtask

  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
    int base;
    base = done_cnt;
    push_exp(a, b, poke);
    @(negedge clk_i);
    mcand_i = a; mplier_i = b; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk_i);
      start_i = 1'b1;
      repeat (2) @(negedge clk_i);
      start_i = 1'b0;
    end
    wait (done_cnt == base + 1);
  endtask

  initial begin
    logic [2*W-1:0] held;
    int base;
    repeat (3) @(negedge clk_i);
    chk(idle_o == 1'b1, "R1 idle in reset", idle_o, 1);
    chk(product_o == '0, "R1 product in reset", product_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(idle_o == 1'b1, "R1 idle after reset", idle_o, 1);
    chk(product_o == '0, "R1 product after reset", product_o, 0);

    // R2: no start, stays idle
    repeat (5) begin
      @(negedge clk_i);
      chk(idle_o == 1'b1, "R2 idle hold", idle_o, 1);
    end

    // corners
    run_mul(8'hFF, 8'hFF, 1'b0);
    run_mul(8'h00, 8'hFF, 1'b0);
    run_mul(8'hFF, 8'h00, 1'b0);
    run_mul(8'h80, 8'h01, 1'b0);
    run_mul(8'h01, 8'h80, 1'b0);

    // R6: operand changes while idle leave product alone
    @(negedge clk_i);
    held = product_o;
    repeat (4) begin
      mcand_i = mcand_i + 8'h35; mplier_i = mplier_i ^ 8'hA7;
      @(negedge clk_i);
      chk(product_o == held, "R6 product held", product_o, held);
      chk(idle_o == 1'b1, "R6 idle held", idle_o, 1);
    end

    // exhaustive 4-bit operands
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        run_mul(W'(i), W'(j), 1'b0);

    // R5: start pulsed mid-run
    run_mul(8'hC3, 8'h5A, 1'b1);
    run_mul(8'h07, 8'hFF, 1'b1);

    // R7: start held across a completion
    base = done_cnt;
    push_exp(8'h9D, 8'h6B, 1'b0);
    push_exp(8'h9D, 8'h6B, 1'b0);
    @(negedge clk_i);
    mcand_i = 8'h9D; mplier_i = 8'h6B; start_i = 1'b1;
    wait (done_cnt == base + 1);
    @(negedge clk_i);
    chk(idle_o == 1'b0, "R7 single idle cycle", idle_o, 0);
    start_i = 1'b0;
    wait (done_cnt == base + 2);

    // random 8-bit operands
    for (int k = 0; k < 200; k++)
      run_mul(W'($urandom), W'($urandom), 1'b0);

    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R3 all runs scored", exp_q.size(), 0);
    finish_run();
  end
endmodule